// File: doc/BRIEF.md
# Max-Log Trellis State Metric Step Unit

This block advances the state-metric vector of a trellis soft-output decoder by one trellis step, in either the forward or the backward direction. It holds the current metric vector in its own register. For every state it forms the saturating sum of each connected neighbour's metric and the matching branch metric, keeps the largest sum, and writes the result back as the next vector. The combine is a plain maximum, with no correction term.

Because the metrics grow with each step, the block can normalize a new vector. Normalization subtracts the largest entry of the vector from every entry, so the best state becomes zero. It costs three extra pipeline stages. The caller chooses, for each step, whether to skip normalization, apply it on every step, or apply it only on every fourth step. The choice sets the spacing between accepted steps: 2 cycles without normalization and 4 cycles with it. At a window boundary the vector can be loaded as all states equal or as a single known start state.

The trellis is a shift-register trellis with 64 states and 4 branches per state. All metrics are 9-bit two's-complement values with 2 fraction bits.

Top module: `maxlog_metric_step`

## Requirements
- R1: Each sum saturates to the 9-bit range: results above +255 become +255 (63.75) and results below -256 become -256. No sum ever wraps.
- R2: With dirBackward=0 (forward), new[n] = max over k of sat(old[p] + g[n][k]), where p = (n >> 2) | (k << 4). Branch metric g[n][k] sits at bits ((n*4+k)*9) +: 9 of branchMetrics. Metric n sits at bits (n*9) +: 9 of metricOut.
- R3: With dirBackward=1 (backward), new[n] = max over k of sat(old[s] + g[n][k]), where s = ((n << 2) | k) mod 64. The arithmetic is the same as in the forward direction.
- R4: A step without normalization raises resultValid for one cycle, one clock after the edge that accepted it. stepReady returns in that same cycle, so steps are accepted every 2 cycles.
- R5: A normalized step raises resultValid three clocks after the accepting edge, so steps are accepted every 4 cycles.
- R6: In a normalized step every entry becomes sat(new[n] - max(new)). The largest entry is then 0.
- R7: The normMode field selects the normalization: 0 = never, 1 or 3 = every step, 2 = coarse. In coarse mode only the 4th, 8th, ... step accepted since the last load or reset is normalized. The steps in between behave as in R4.
- R8: While stepReady is low, stepValid, loadInit and all data inputs are ignored. metricOut then changes only as the accepted step dictates.
- R9: loadInit, when stepReady is high, loads the vector on that edge. With initKnown=0 every entry becomes 0. With initKnown=1, state initState becomes 0 and every other state becomes -256. The load wins over a simultaneous stepValid, produces no resultValid, and restarts the coarse step count.
- R10: After reset the vector is all zeros, stepReady is 1, resultValid is 0 and the coarse step count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stepValid | input | 1 | Request one recursion step |
| stepReady | output | 1 | A step or a load can be accepted this cycle |
| dirBackward | input | 1 | 0 = forward connectivity, 1 = backward |
| normMode | input | 2 | Normalization choice for this step |
| branchMetrics | input | 2304 | 64 x 4 branch metrics, 9 bits each |
| loadInit | input | 1 | Load an initial vector |
| initKnown | input | 1 | 0 = all states equal, 1 = single start state |
| initState | input | 6 | Start state used when initKnown=1 |
| resultValid | output | 1 | One-cycle pulse: metricOut holds a new step result |
| metricOut | output | 576 | Current metric vector, 64 x 9 bits |

## Verification
The assertions take for granted that stepValid, loadInit, initKnown and normMode carry known values in every cycle after reset. They also take for granted that the branch metrics are valid in any cycle where stepValid is high and stepReady is high. The bench changes its inputs only on the falling clock edge, so every input is settled well before the rising edge that samples it. During busy cycles the bench deliberately scrambles the data inputs and raises stepValid and loadInit, while the inputs still stay at known values. It drops both requests in the cycle in which stepReady returns, so no unintended step is accepted.

// File: rtl/mlms_pkg.sv
package mlms_pkg;

  typedef enum logic [1:0] {
    NORM_OFF       = 2'd0,
    NORM_EVERY     = 2'd1,
    NORM_COARSE    = 2'd2,
    NORM_EVERY_ALT = 2'd3
  } normMode_e;

  typedef struct packed {
    logic loadEn;
    logic acsEn;
    logic grpEn;
    logic maxEn;
    logic writeRaw;
    logic writeNorm;
  } strobes_t;

endpackage

// File: rtl/mlms_ctrl.sv
module mlms_ctrl
  import mlms_pkg::*;
#(
  parameter int NORM_PERIOD = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepValid,
  input  logic       loadInit,
  input  logic [1:0] normMode,
  output logic       stepReady,
  output logic       resultValid,
  output strobes_t   strobes
);

  localparam int CW = (NORM_PERIOD > 1) ? $clog2(NORM_PERIOD) : 1;

  typedef enum logic [1:0] {PH_IDLE, PH_ACS, PH_GMAX, PH_VMAX} phase_e;

  phase_e        phase, phaseNext;
  logic          doNorm, wantNorm;
  logic [CW-1:0] stepCnt;
  logic          accept, load;

  assign stepReady = (phase == PH_IDLE);
  assign load      = stepReady & loadInit;
  assign accept    = stepReady & stepValid & ~loadInit;

  always_comb begin
    case (normMode_e'(normMode))
      NORM_OFF:    wantNorm = 1'b0;
      NORM_COARSE: wantNorm = (stepCnt == CW'(NORM_PERIOD - 1));
      default:     wantNorm = 1'b1;
    endcase
  end

  always_comb begin
    strobes.loadEn    = load;
    strobes.acsEn     = accept;
    strobes.grpEn     = (phase == PH_ACS) & doNorm;
    strobes.writeRaw  = (phase == PH_ACS) & ~doNorm;
    strobes.maxEn     = (phase == PH_GMAX);
    strobes.writeNorm = (phase == PH_VMAX);
  end

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE: if (accept) phaseNext = PH_ACS;
      PH_ACS:  phaseNext = doNorm ? PH_GMAX : PH_IDLE;
      PH_GMAX: phaseNext = PH_VMAX;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      doNorm      <= 1'b0;
      stepCnt     <= '0;
      resultValid <= 1'b0;
    end else begin
      phase       <= phaseNext;
      resultValid <= strobes.writeRaw | strobes.writeNorm;
      if (accept) doNorm <= wantNorm;
      if (load) begin
        stepCnt <= '0;
      end else if (accept) begin
        stepCnt <= (stepCnt == CW'(NORM_PERIOD - 1)) ? '0 : stepCnt + 1'b1;
      end
    end
  end

  // R8: once a step is taken the unit is busy on the next cycle
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !stepReady);

  // R4: the result strobe is a single-cycle pulse
  assert_result_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R5: at most one pipeline strobe per cycle
  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R5: the normalized write always follows the max-reduction stage
  assert_norm_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeNorm |-> $past(strobes.maxEn));

endmodule

// File: rtl/mlms_datapath.sv
module mlms_datapath
  import mlms_pkg::*;
#(
  parameter int NUM_STATES = 64,
  parameter int NUM_BR     = 4,
  parameter int METRIC_W   = 9,
  parameter int NUM_GROUPS = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobes_t                           strobes,
  input  logic                               dirBackward,
  input  logic [NUM_STATES*NUM_BR*METRIC_W-1:0] branchMetrics,
  input  logic                               initKnown,
  input  logic [$clog2(NUM_STATES)-1:0]      initState,
  output logic [NUM_STATES*METRIC_W-1:0]     metricOut
);

  localparam int SW       = $clog2(NUM_STATES);
  localparam int BW       = $clog2(NUM_BR);
  localparam int GRP_SIZE = NUM_STATES / NUM_GROUPS;

  typedef logic signed [METRIC_W-1:0] metric_t;

  localparam metric_t MAXV = {1'b0, {(METRIC_W-1){1'b1}}};
  localparam metric_t MINV = {1'b1, {(METRIC_W-1){1'b0}}};

  function automatic metric_t satAdd(metric_t a, metric_t b);
    logic signed [METRIC_W:0] s;
    s = {a[METRIC_W-1], a} + {b[METRIC_W-1], b};
    if (s[METRIC_W] != s[METRIC_W-1]) return s[METRIC_W] ? MINV : MAXV;
    return s[METRIC_W-1:0];
  endfunction

  function automatic metric_t satSub(metric_t a, metric_t b);
    logic signed [METRIC_W:0] d;
    d = {a[METRIC_W-1], a} - {b[METRIC_W-1], b};
    if (d[METRIC_W] != d[METRIC_W-1]) return d[METRIC_W] ? MINV : MAXV;
    return d[METRIC_W-1:0];
  endfunction

  metric_t stateVec [NUM_STATES];
  metric_t acsVec   [NUM_STATES];
  metric_t acsNext  [NUM_STATES];
  metric_t cand     [NUM_STATES][NUM_BR];
  metric_t grpMax   [NUM_GROUPS];
  metric_t grpMaxNext [NUM_GROUPS];
  metric_t vecMax, vecMaxNext;
  metric_t curMax;

  // Add stage: neighbour metric plus branch metric, both directions share the adder
  for (genvar n = 0; n < NUM_STATES; n++) begin : g_state
    for (genvar k = 0; k < NUM_BR; k++) begin : g_branch
      localparam int PRED = (n >> BW) | (k << (SW - BW));
      localparam int SUCC = ((n << BW) | k) % NUM_STATES;
      assign cand[n][k] = satAdd(dirBackward ? stateVec[SUCC] : stateVec[PRED],
                                 metric_t'(branchMetrics[(n*NUM_BR+k)*METRIC_W +: METRIC_W]));
    end
    assign metricOut[n*METRIC_W +: METRIC_W] = stateVec[n];
  end

  // Compare-select: plain maximum, no correction term
  always_comb begin
    for (int n = 0; n < NUM_STATES; n++) begin
      acsNext[n] = cand[n][0];
      for (int k = 1; k < NUM_BR; k++) begin
        if (cand[n][k] > acsNext[n]) acsNext[n] = cand[n][k];
      end
    end
  end

  // Normalization stage 1: per-group maxima
  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      grpMaxNext[g] = acsVec[g*GRP_SIZE];
      for (int i = 1; i < GRP_SIZE; i++) begin
        if (acsVec[g*GRP_SIZE+i] > grpMaxNext[g]) grpMaxNext[g] = acsVec[g*GRP_SIZE+i];
      end
    end
  end

  // Normalization stage 2: vector maximum
  always_comb begin
    vecMaxNext = grpMax[0];
    for (int g = 1; g < NUM_GROUPS; g++) begin
      if (grpMax[g] > vecMaxNext) vecMaxNext = grpMax[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < NUM_STATES; n++) begin
        stateVec[n] <= '0;
        acsVec[n]   <= '0;
      end
      for (int g = 0; g < NUM_GROUPS; g++) grpMax[g] <= '0;
      vecMax <= '0;
    end else begin
      if (strobes.acsEn) for (int n = 0; n < NUM_STATES; n++) acsVec[n] <= acsNext[n];
      if (strobes.grpEn) for (int g = 0; g < NUM_GROUPS; g++) grpMax[g] <= grpMaxNext[g];
      if (strobes.maxEn) vecMax <= vecMaxNext;
      if (strobes.loadEn) begin
        for (int n = 0; n < NUM_STATES; n++)
          stateVec[n] <= (initKnown && (SW'(n) != initState)) ? MINV : '0;
      end else if (strobes.writeRaw) begin
        for (int n = 0; n < NUM_STATES; n++) stateVec[n] <= acsVec[n];
      end else if (strobes.writeNorm) begin
        // Normalization stage 3: subtract the maximum
        for (int n = 0; n < NUM_STATES; n++) stateVec[n] <= satSub(acsVec[n], vecMax);
      end
    end
  end

  always_comb begin
    curMax = stateVec[0];
    for (int n = 1; n < NUM_STATES; n++) if (stateVec[n] > curMax) curMax = stateVec[n];
  end

  // R6: after a normalized write the best state sits at zero
  assert_norm_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeNorm |=> (curMax == '0));

  // R9: an equal-states load leaves every entry at zero
  assert_uniform_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEn && !initKnown) |=> (curMax == '0 && stateVec[NUM_STATES-1] == '0 && stateVec[0] == '0));

endmodule

// File: rtl/maxlog_metric_step.sv
module maxlog_metric_step
  import mlms_pkg::*;
#(
  parameter int NUM_STATES  = 64,
  parameter int NUM_BR      = 4,
  parameter int METRIC_W    = 9,
  parameter int NORM_PERIOD = 4,
  parameter int NUM_GROUPS  = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  stepValid,
  output logic                                  stepReady,
  input  logic                                  dirBackward,
  input  logic [1:0]                            normMode,
  input  logic [NUM_STATES*NUM_BR*METRIC_W-1:0] branchMetrics,
  input  logic                                  loadInit,
  input  logic                                  initKnown,
  input  logic [$clog2(NUM_STATES)-1:0]         initState,
  output logic                                  resultValid,
  output logic [NUM_STATES*METRIC_W-1:0]        metricOut
);

  strobes_t strobes;

  mlms_ctrl #(.NORM_PERIOD(NORM_PERIOD)) u_ctrl (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .loadInit(loadInit),
    .normMode(normMode), .stepReady(stepReady), .resultValid(resultValid),
    .strobes(strobes)
  );

  mlms_datapath #(
    .NUM_STATES(NUM_STATES), .NUM_BR(NUM_BR), .METRIC_W(METRIC_W), .NUM_GROUPS(NUM_GROUPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dirBackward(dirBackward),
    .branchMetrics(branchMetrics), .initKnown(initKnown), .initState(initState),
    .metricOut(metricOut)
  );

endmodule

// File: tb/maxlog_metric_step_tb.sv
module maxlog_metric_step_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 64, NB = 4, W = 9, SW = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic stepValid = 1'b0, dirBackward = 1'b0, loadInit = 1'b0, initKnown = 1'b0;
  logic [1:0] normMode = 2'd0;
  logic [SW-1:0] initState = '0;
  logic [NS*NB*W-1:0] branchMetrics = '0;
  logic stepReady, resultValid;
  logic [NS*W-1:0] metricOut;

  int refVec[NS];
  int gm[NS][NB];
  int nChecks = 0, nFails = 0, stepCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maxlog_metric_step u_dut (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .stepReady(stepReady),
    .dirBackward(dirBackward), .normMode(normMode), .branchMetrics(branchMetrics),
    .loadInit(loadInit), .initKnown(initKnown), .initState(initState),
    .resultValid(resultValid), .metricOut(metricOut)
  );

  function automatic int sat(int v);
    if (v > 255) return 255;
    if (v < -256) return -256;
    return v;
  endfunction

  function automatic int outAt(int n);
    logic signed [W-1:0] v;
    v = metricOut[n*W +: W];
    return int'(v);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkVec(string tag);
    int bad;
    bad = -1;
    for (int n = 0; n < NS; n++) if (bad < 0 && outAt(n) != refVec[n]) bad = n;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s state %0d", tag, bad), outAt(bad), refVec[bad]);
  endtask

  task automatic packGamma();
    for (int n = 0; n < NS; n++)
      for (int k = 0; k < NB; k++) branchMetrics[(n*NB+k)*W +: W] = W'(gm[n][k]);
  endtask

  task automatic fillGamma(bit wide);
    for (int n = 0; n < NS; n++)
      for (int k = 0; k < NB; k++)
        gm[n][k] = wide ? int'($urandom_range(0, 511)) - 256 : int'($urandom_range(0, 80)) - 40;
    packGamma();
  endtask

  task automatic refStep(bit dir, bit norm);
    int nv[NS];
    int mx, nb;
    for (int n = 0; n < NS; n++) begin
      nv[n] = -100000;
      for (int k = 0; k < NB; k++) begin
        nb = dir ? (((n << 2) | k) % NS) : ((n >> 2) | (k << 4));
        if (sat(refVec[nb] + gm[n][k]) > nv[n]) nv[n] = sat(refVec[nb] + gm[n][k]);
      end
    end
    if (norm) begin
      mx = nv[0];
      for (int n = 1; n < NS; n++) if (nv[n] > mx) mx = nv[n];
      for (int n = 0; n < NS; n++) nv[n] = sat(nv[n] - mx);
    end
    for (int n = 0; n < NS; n++) refVec[n] = nv[n];
  endtask

  // Called at a falling edge with stepReady high.
  task automatic doStep(bit dir, int mode, bit disturb, string req);
    bit norm;
    int cnt, expLat;
    norm = (mode == 0) ? 1'b0 : (mode == 2) ? (stepCount % 4 == 3) : 1'b1;
    expLat = norm ? 4 : 2;
    check(stepReady == 1'b1, {req, " ready before step"}, int'(stepReady), 1);
    dirBackward = dir; normMode = 2'(mode); stepValid = 1'b1;
    refStep(dir, norm);
    @(negedge clk);
    check(stepReady == 1'b0, "R8 busy after accept", int'(stepReady), 0);
    cnt = 1;
    stepValid = disturb; loadInit = disturb;
    if (disturb) begin fillGamma(1'b1); dirBackward = ~dir; initKnown = 1'b1; end
    while (!resultValid && cnt < 20) begin
      @(negedge clk);
      cnt++;
      if (disturb && !resultValid) fillGamma(1'b1);
    end
    stepValid = 1'b0; loadInit = 1'b0;
    check(cnt == expLat, norm ? $sformatf("R5 %s normalized latency", req)
                              : $sformatf("R4 %s raw latency", req), cnt, expLat);
    checkVec(disturb ? $sformatf("R8 %s vector with busy-time noise", req)
                     : (norm ? $sformatf("R6 %s normalized vector", req) : req));
    stepCount++;
  endtask

  task automatic doLoad(bit known, int st);
    loadInit = 1'b1; initKnown = known; initState = SW'(st); stepValid = 1'b1;
    @(negedge clk);
    loadInit = 1'b0; stepValid = 1'b0;
    for (int n = 0; n < NS; n++) refVec[n] = (known && n != st) ? -256 : 0;
    stepCount = 0;
    check(resultValid == 1'b0, "R9 load gives no result pulse", int'(resultValid), 0);
    check(stepReady == 1'b1, "R9 ready after load", int'(stepReady), 1);
    checkVec(known ? "R9 known-state load" : "R9 uniform load");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < NS; n++) refVec[n] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(stepReady == 1'b1, "R10 stepReady after reset", int'(stepReady), 1);
    check(resultValid == 1'b0, "R10 resultValid after reset", int'(resultValid), 0);
    checkVec("R10 vector zero after reset");

    // R1 positive saturation
    doLoad(1'b0, 0);
    for (int n = 0; n < NS; n++) for (int k = 0; k < NB; k++) gm[n][k] = 255;
    packGamma();
    doStep(1'b0, 0, 1'b0, "R1 positive step");
    doStep(1'b0, 0, 1'b0, "R1 positive saturation");
    check(outAt(5) == 255, "R1 clamps at +255", outAt(5), 255);
    // R1 negative saturation
    for (int n = 0; n < NS; n++) for (int k = 0; k < NB; k++) gm[n][k] = -256;
    packGamma();
    doStep(1'b1, 0, 1'b0, "R1 negative step");
    doStep(1'b1, 0, 1'b0, "R1 negative saturation");
    check(outAt(17) == -256, "R1 clamps at -256", outAt(17), -256);

    // R2 forward connectivity from a known state
    doLoad(1'b1, 37);
    for (int i = 0; i < 4; i++) begin fillGamma(1'b0); doStep(1'b0, 0, 1'b0, "R2 forward"); end
    // R3 backward connectivity
    doLoad(1'b1, 9);
    for (int i = 0; i < 4; i++) begin fillGamma(1'b0); doStep(1'b1, 0, 1'b0, "R3 backward"); end
    // R6 every-step normalization with both codes
    doLoad(1'b1, 0);
    for (int i = 0; i < 4; i++) begin fillGamma(1'b1); doStep(i[0], (i < 2) ? 1 : 3, 1'b0, "R6 every step"); end
    // R7 coarse schedule over two periods
    doLoad(1'b0, 0);
    for (int i = 0; i < 8; i++) begin fillGamma(1'b0); doStep(1'b0, 2, 1'b0, "R7 coarse"); end
    // R8 noise while busy, raw and normalized
    fillGamma(1'b0); doStep(1'b0, 0, 1'b1, "R8 raw");
    fillGamma(1'b0); doStep(1'b1, 1, 1'b1, "R8 norm");

    // Mixed random traffic
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 19) == 0) doLoad(1'($urandom_range(0, 1)), int'($urandom_range(0, NS-1)));
      fillGamma(1'($urandom_range(0, 3) == 0));
      doStep(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), 1'($urandom_range(0, 4) == 0),
             "R2 R3 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule